// File: doc/BRIEF.md
# Bus Address Decoder with Built-in Error Responder

This block sits between the single master of a lightweight on-chip bus (AHB-Lite style) and its slaves. From the address bus alone it raises one select line for the slave that owns the address: a 1 MB memory window or a 1 MB peripheral window directly above it. No request, grant or arbitration logic is present, because only one master drives the bus.

An address that falls in neither window selects a small responder kept inside the block. An idle or busy transfer there completes at once with an OKAY response. An active transfer (nonsequential or sequential) gets the standard two-cycle ERROR reply. In the first cycle the responder drives ready low with ERROR. In the second it drives ready high with ERROR. The system read mux then forwards these ready and response values to the master.

Top module: `ahb_addr_decoder`

## Requirements
- R1: `selMem` is high exactly when `hAddr` lies in 0xC2000000..0xC20FFFFF.
- R2: `selPeri` is high exactly when `hAddr` lies in 0xC2100000..0xC21FFFFF.
- R3: `selDefault` is high exactly when neither window matches, so exactly one of the three selects is high for every address.
- R4: The selects are combinational in `hAddr` alone. They settle in the same cycle and do not depend on `hTrans`, `hReady`, the clock or reset.
- R5: While `hResetN` is low, and in the first cycle after it rises, `dfltReadyOut` is 1 and `dfltResp` is OKAY (2'b00).
- R6: An unmapped transfer with `hTrans` IDLE (2'b00) or BUSY (2'b01) leaves `dfltReadyOut`=1 and `dfltResp`=OKAY in the next cycle.
- R7: An unmapped transfer with `hTrans` NONSEQ (2'b10) or SEQ (2'b11), sampled with `hReady`=1, gives `dfltReadyOut`=0 and `dfltResp`=ERROR (2'b01) in the next cycle.
- R8: In the cycle after the first error cycle, `dfltReadyOut`=1 and `dfltResp`=ERROR. After that the responder returns to OKAY and ready, unless a new error starts.
- R9: An address phase sampled with `hReady`=0 is ignored by the responder.
- R10: Active transfers to the memory or peripheral window leave the responder at OKAY and ready.
- R11: An active unmapped transfer sampled during the second error cycle starts a new two-cycle error at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hClk | input | 1 | Bus clock, rising edge |
| hResetN | input | 1 | Active-low reset |
| hAddr | input | 32 | Address of the current address phase |
| hTrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| hReady | input | 1 | Bus ready; an address phase is accepted only when high |
| selMem | output | 1 | Select for the memory window |
| selPeri | output | 1 | Select for the peripheral window |
| selDefault | output | 1 | Select for the internal error responder |
| dfltReadyOut | output | 1 | Ready from the internal responder |
| dfltResp | output | 2 | Response from the internal responder: 00 OKAY, 01 ERROR |

## Verification
The decode is tried with addresses at both edges of each window, at interior points, and just outside each window. Each of these is paired with a different transfer type and ready level, so that a select that leaks on `hTrans` or `hReady`, or an off-by-one bound, shows up. The responder is driven with each transfer type against unmapped, memory and peripheral addresses. Each such transfer is sampled both with ready high and with ready low, which separates a correct qualifier from one that ignores ready or ignores the transfer type. Back-to-back errors and a reset during an error show that the second error cycle is a valid acceptance point and that reset wins.

// File: rtl/ahbdec_pkg.sv
package ahbdec_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_SPLIT = 2'b11
  } hresp_e;

  typedef enum logic [1:0] {
    DS_IDLE = 2'b00,
    DS_ERR1 = 2'b01,
    DS_ERR2 = 2'b10
  } dsState_e;

  // strobes from the responder control to the response datapath
  typedef struct packed {
    logic holdLow;  // stretch the transfer (first error cycle)
    logic flagErr;  // drive ERROR on the response lines
  } rspStrobe_t;

endpackage

// File: rtl/ahbdec_ctrl.sv
module ahbdec_ctrl
  import ahbdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hReady,
  input  logic [1:0] hTrans,
  input  logic       selDefault,
  output rspStrobe_t strobe
);

  dsState_e state;
  dsState_e stateNext;
  logic     acceptErr;

  // an active transfer to the unmapped space, taken only on a ready cycle
  assign acceptErr = hReady && selDefault &&
                     ((hTrans == TR_NONSEQ) || (hTrans == TR_SEQ));

  always_comb begin
    stateNext = state;
    unique case (state)
      DS_IDLE: stateNext = acceptErr ? DS_ERR1 : DS_IDLE;
      DS_ERR1: stateNext = DS_ERR2;
      DS_ERR2: stateNext = acceptErr ? DS_ERR1 : DS_IDLE;
      default: stateNext = DS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= DS_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.holdLow = (state == DS_ERR1);
    strobe.flagErr = (state != DS_IDLE);
  end

endmodule

// File: rtl/ahbdec_path.sv
module ahbdec_path
  import ahbdec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int N_REGION = 2,
  parameter logic [N_REGION-1:0][ADDR_W-1:0] REGION_BASE = '0,
  parameter logic [N_REGION-1:0][5:0]        REGION_LOG2 = '0
) (
  input  logic [ADDR_W-1:0]   hAddr,
  input  rspStrobe_t          strobe,
  output logic [N_REGION-1:0] regionSel,
  output logic                selDefault,
  output logic                readyOut,
  output logic [1:0]          resp
);

  logic [N_REGION-1:0] hit;

  for (genvar i = 0; i < N_REGION; i++) begin : g_region
    localparam int SPAN = int'(REGION_LOG2[i]);
    localparam logic [ADDR_W-1:0] BASE = REGION_BASE[i];
    assign hit[i] = ((hAddr >> SPAN) == (BASE >> SPAN));
  end

  // lowest index wins, so the selects stay one-hot even if a map overlaps
  always_comb begin
    regionSel = '0;
    for (int i = N_REGION - 1; i >= 0; i--) begin
      if (hit[i]) begin
        regionSel    = '0;
        regionSel[i] = 1'b1;
      end
    end
  end

  assign selDefault = ~|hit;
  assign readyOut   = ~strobe.holdLow;
  assign resp       = strobe.flagErr ? RSP_ERROR : RSP_OKAY;

endmodule

// File: rtl/ahb_addr_decoder.sv
module ahb_addr_decoder
  import ahbdec_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] MEM_BASE  = 32'hC200_0000,
  parameter int          MEM_LOG2  = 20,
  parameter logic [31:0] PERI_BASE = 32'hC210_0000,
  parameter int          PERI_LOG2 = 20
) (
  input  logic              hClk,
  input  logic              hResetN,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic [1:0]        hTrans,
  input  logic              hReady,
  output logic              selMem,
  output logic              selPeri,
  output logic              selDefault,
  output logic              dfltReadyOut,
  output logic [1:0]        dfltResp
);

  localparam int N_REGION = 2;
  localparam logic [N_REGION-1:0][ADDR_W-1:0] BASES =
    {PERI_BASE[ADDR_W-1:0], MEM_BASE[ADDR_W-1:0]};
  localparam logic [N_REGION-1:0][5:0] LOG2S =
    {6'(PERI_LOG2), 6'(MEM_LOG2)};

  rspStrobe_t          strobe;
  logic [N_REGION-1:0] regionSel;
  logic                dfltSel;

  ahbdec_path #(
    .ADDR_W     (ADDR_W),
    .N_REGION   (N_REGION),
    .REGION_BASE(BASES),
    .REGION_LOG2(LOG2S)
  ) u_path (
    .hAddr     (hAddr),
    .strobe    (strobe),
    .regionSel (regionSel),
    .selDefault(dfltSel),
    .readyOut  (dfltReadyOut),
    .resp      (dfltResp)
  );

  ahbdec_ctrl u_ctrl (
    .clk       (hClk),
    .rstN      (hResetN),
    .hReady    (hReady),
    .hTrans    (hTrans),
    .selDefault(dfltSel),
    .strobe    (strobe)
  );

  assign selMem     = regionSel[0];
  assign selPeri    = regionSel[1];
  assign selDefault = dfltSel;

endmodule

// File: rtl/ahb_addr_decoder_chk.sv
module ahb_addr_decoder_chk (
  input logic        hClk,
  input logic        hResetN,
  input logic [31:0] hAddr,
  input logic [1:0]  hTrans,
  input logic        hReady,
  input logic        selMem,
  input logic        selPeri,
  input logic        selDefault,
  input logic        dfltReadyOut,
  input logic [1:0]  dfltResp
);

  logic activeMiss;
  assign activeMiss = hReady && selDefault && hTrans[1];

  AST_SEL_ONEHOT: assert property (@(posedge hClk) disable iff (!hResetN)
    $onehot({selMem, selPeri, selDefault})); // R3

  AST_MEM_WINDOW: assert property (@(posedge hClk) disable iff (!hResetN)
    (hAddr[31:20] == 12'hC20) |-> selMem); // R1

  AST_PERI_WINDOW: assert property (@(posedge hClk) disable iff (!hResetN)
    (hAddr[31:20] == 12'hC21) |-> selPeri); // R2

  AST_ERR_FIRST: assert property (@(posedge hClk) disable iff (!hResetN)
    (dfltReadyOut && activeMiss) |=> (!dfltReadyOut && dfltResp == 2'b01)); // R7

  AST_ERR_SECOND: assert property (@(posedge hClk) disable iff (!hResetN)
    !dfltReadyOut |=> (dfltReadyOut && dfltResp == 2'b01)); // R8

  AST_NO_SPURIOUS_ERR: assert property (@(posedge hClk) disable iff (!hResetN)
    (dfltReadyOut && !activeMiss) |=> (dfltReadyOut && dfltResp == 2'b00)); // R9

  AST_WAIT_IS_ERR: assert property (@(posedge hClk) disable iff (!hResetN)
    !dfltReadyOut |-> (dfltResp == 2'b01)); // R7

endmodule

bind ahb_addr_decoder ahb_addr_decoder_chk u_chk (
  .hClk        (hClk),
  .hResetN     (hResetN),
  .hAddr       (hAddr),
  .hTrans      (hTrans),
  .hReady      (hReady),
  .selMem      (selMem),
  .selPeri     (selPeri),
  .selDefault  (selDefault),
  .dfltReadyOut(dfltReadyOut),
  .dfltResp    (dfltResp)
);

// File: tb/ahb_addr_decoder_tb.sv
module ahb_addr_decoder_tb;

  logic        hClk = 1'b0;
  logic        hResetN = 1'b0;
  logic [31:0] hAddr = '0;
  logic [1:0]  hTrans = 2'b00;
  logic        hReady = 1'b1;
  logic        selMem, selPeri, selDefault, dfltReadyOut;
  logic [1:0]  dfltResp;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 hClk = ~hClk; // 50 MHz

  ahb_addr_decoder u_dut (
    .hClk(hClk), .hResetN(hResetN), .hAddr(hAddr), .hTrans(hTrans),
    .hReady(hReady), .selMem(selMem), .selPeri(selPeri),
    .selDefault(selDefault), .dfltReadyOut(dfltReadyOut), .dfltResp(dfltResp)
  );

  localparam int NV = 12;
  // selects expected as {default, peri, mem}
  localparam logic [31:0] V_ADDR [NV] = '{
    32'hC200_0000, 32'hC20F_FFFF, 32'hC20A_BCD4, 32'hC210_0000,
    32'hC21F_FFFC, 32'hC218_03A0, 32'hC1FF_FFFF, 32'hC220_0000,
    32'h0000_0000, 32'hFFFF_FFFF, 32'h4200_0000, 32'hC300_0000 };
  localparam logic [2:0] V_SEL [NV] = '{
    3'b001, 3'b001, 3'b001, 3'b010, 3'b010, 3'b010,
    3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100 };
  localparam logic [1:0] V_TRANS [NV] = '{
    2'b10, 2'b00, 2'b11, 2'b01, 2'b10, 2'b00,
    2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b01 };
  localparam logic V_READY [NV] = '{
    1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1,
    1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0 };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkRsp(input string req, input logic rdy, input logic [1:0] rsp);
    chk(req, {31'd0, dfltReadyOut}, {31'd0, rdy});
    chk(req, {30'd0, dfltResp}, {30'd0, rsp});
  endtask

  // drive at a falling edge; outputs registered at the next rising edge
  // are then checked at the following falling edge
  task automatic drive(input logic [31:0] a, input logic [1:0] t, input logic r);
    hAddr = a; hTrans = t; hReady = r;
    @(negedge hClk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    // R5: reset state
    @(negedge hClk);
    drive(32'hC300_0000, 2'b10, 1'b1);
    chkRsp("R5 in reset", 1'b1, 2'b00);
    hResetN = 1'b1;
    drive(32'h0, 2'b00, 1'b1);
    chkRsp("R5 after reset", 1'b1, 2'b00);

    // R1 R2 R3 R4: decode table with varied transfer type and ready
    for (int i = 0; i < NV; i++) begin
      hAddr = V_ADDR[i]; hTrans = V_TRANS[i]; hReady = V_READY[i];
      #2;
      chk("R1 R2 R3 R4 select", {29'd0, selDefault, selPeri, selMem}, {29'd0, V_SEL[i]});
      @(negedge hClk);
    end

    // restart the responder from a known state
    hResetN = 1'b0; hTrans = 2'b00;
    @(negedge hClk);
    hResetN = 1'b1;
    @(negedge hClk);

    // R6: idle and busy to unmapped
    drive(32'hD000_0000, 2'b00, 1'b1);
    chkRsp("R6 idle", 1'b1, 2'b00);
    drive(32'hD000_0004, 2'b01, 1'b1);
    chkRsp("R6 busy", 1'b1, 2'b00);

    // R10: active transfers to mapped windows
    drive(32'hC200_0010, 2'b10, 1'b1);
    chkRsp("R10 mem", 1'b1, 2'b00);
    drive(32'hC210_0020, 2'b11, 1'b1);
    chkRsp("R10 peri", 1'b1, 2'b00);

    // R9: active unmapped while ready low
    drive(32'hD000_0000, 2'b10, 1'b0);
    chkRsp("R9 ready low", 1'b1, 2'b00);

    // R7 R8: single error
    drive(32'hD000_0000, 2'b10, 1'b1);
    chkRsp("R7 first cycle", 1'b0, 2'b01);
    drive(32'hC200_0000, 2'b00, 1'b0);
    chkRsp("R8 second cycle", 1'b1, 2'b01);
    drive(32'hC200_0000, 2'b00, 1'b1);
    chkRsp("R8 back to okay", 1'b1, 2'b00);

    // R11: back-to-back errors, second accepted in the second error cycle
    drive(32'h1000_0000, 2'b11, 1'b1);
    chkRsp("R11 first err cycle1", 1'b0, 2'b01);
    drive(32'h1000_0004, 2'b10, 1'b0);
    chkRsp("R11 first err cycle2", 1'b1, 2'b01);
    drive(32'h1000_0004, 2'b10, 1'b1);
    chkRsp("R11 second err cycle1", 1'b0, 2'b01);
    drive(32'h1000_0008, 2'b00, 1'b0);
    chkRsp("R11 second err cycle2", 1'b1, 2'b01);
    drive(32'h1000_0008, 2'b00, 1'b1);
    chkRsp("R11 settle", 1'b1, 2'b00);

    // R5: reset during an error
    drive(32'hE000_0000, 2'b10, 1'b1);
    chkRsp("R7 before reset", 1'b0, 2'b01);
    hResetN = 1'b0;
    #2;
    chkRsp("R5 reset mid error", 1'b1, 2'b00);
    hTrans = 2'b00;
    @(negedge hClk);
    hResetN = 1'b1;
    @(negedge hClk);
    chkRsp("R5 after mid reset", 1'b1, 2'b00);

    finishRun();
  end

endmodule